// File: doc/BRIEF.md
# Multi-Mode Counter Channel with Capture Registers

This block is a single 32-bit counting channel. It is driven by three external signals: a clock/phase-A line, a direction/phase-B line and a clear/capture line. A mode select picks one of three ways to count. In step-and-direction counting, a rising edge on the first line moves the count by one, and the second line gives the sign. In 4x quadrature decoding, every edge of two phase-shifted encoder signals moves the count by one, and the edge order gives the direction. In pulse timing, the count climbs on an internal reference tick, and edges of the clear/capture line freeze the running value into capture registers.

Before any edge is examined, the external signals are brought into the system clock domain through a two-stage synchronizer. Software strobes can clear the count or capture it at any time. The reference tick is the system clock divided by `REF_DIV`. A slow option divides it by a further `SLOW_FACTOR`. The second capture register exists only when `HAS_LATCH_B` is set, and otherwise reads zero. The system clock must run at least four times faster than the fastest external edge rate.

Top module: `mmc_channel`

## Requirements
- R1: After reset, `count`, `latchA`, `latchB` and `quadErr` are all zero.
- R2: With `modeSel`=0, each rising edge of `inA` raises `count` by one when `inB`=1 and lowers it by one when `inB`=0. The new value is visible by the fourth clock after the input changes.
- R3: With `modeSel`=1, each single edge of `inA` or `inB` changes `count` by one. The sequence (A,B) 00→10→11→01→00 counts up, and the reverse sequence counts down.
- R4: With `modeSel`=1, a step in which A and B change together leaves `count` unchanged and sets `quadErr`, which stays set until `swClear`.
- R5: With `modeSel` 0 or 1, a rising edge on `inCl` copies `count` into `latchA` when `extLatchSel`=1, and zeroes `count` when `extLatchSel`=0. A falling edge on `inCl` does nothing.
- R6: With `modeSel`=2, `count` rises by one every `REF_DIV` clocks, or every `REF_DIV*SLOW_FACTOR` clocks while `slowRef`=1.
- R7: With `modeSel`=2, a rising edge on `inCl` copies `count` into `latchA` and a falling edge copies it into `latchB`. `inCl` never clears the count.
- R8: In every mode, `swClear` zeroes `count` and `quadErr`, and `swLatch` copies `count` into `latchA`.
- R9: While `enable`=0, the count does not step, but clears and captures still act.
- R10: The count wraps modulo 2^32, so a decrement from 0 gives 0xFFFFFFFF.
- R11: A capture in the same cycle as a clear or a step stores the value from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the count to step |
| modeSel | input | 2 | 0 step/direction, 1 quadrature, 2 pulse timing, 3 idle |
| extLatchSel | input | 1 | External modes: 1 makes `inCl` capture, 0 makes it clear |
| slowRef | input | 1 | Pulse timing: use the slowed reference tick |
| swClear | input | 1 | Software clear strobe |
| swLatch | input | 1 | Software capture strobe into `latchA` |
| inA | input | 1 | Asynchronous clock / phase A line |
| inB | input | 1 | Asynchronous direction / phase B line |
| inCl | input | 1 | Asynchronous clear / capture line |
| count | output | 32 | Running count |
| latchA | output | 32 | Capture register A |
| latchB | output | 32 | Capture register B (zero when absent) |
| quadErr | output | 1 | Sticky invalid-quadrature-step flag |

## Verification
The bench walks a full quadrature cycle in both directions and steps the count down through zero. A decoder with the phase relation swapped would count backwards, and a counter that saturates would stick at zero instead of wrapping. It drives both phases at once to confirm that the count holds and the error flag stays set until a software clear. It fires a software clear and a capture in the same cycle, which catches a design that stores the already-cleared value. Pulse timing is checked by the exact tick count between two capture edges, at both prescaler settings, so a wrong divide or a capture landing on the wrong register shows up as a wrong difference.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  typedef enum logic [1:0] {
    MODE_STEPDIR = 2'd0,
    MODE_QUAD    = 2'd1,
    MODE_PULSE   = 2'd2,
    MODE_IDLE    = 2'd3
  } chanMode_e;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
    logic capA;
    logic capB;
    logic errSet;
    logic errClr;
  } dpStrobe_t;
endpackage

// File: rtl/mmc_sync.sv
module mmc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/mmc_refdiv.sv
module mmc_refdiv #(
  parameter int BASE_DIV    = 2,
  parameter int SLOW_FACTOR = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic slow,
  output logic tick
);
  localparam int MAX_DIV = BASE_DIV * SLOW_FACTOR;
  localparam int DW      = (MAX_DIV > 1) ? $clog2(MAX_DIV + 1) : 1;

  logic [DW-1:0] divCnt;
  logic [DW-1:0] limit;

  assign limit = slow ? DW'(MAX_DIV - 1) : DW'(BASE_DIV - 1);
  assign tick  = (divCnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN)                divCnt <= '0;
    else if (divCnt >= limit) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  // A tick restarts the divide window
  assert_tick_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> divCnt == '0);
endmodule

// File: rtl/mmc_ctrl.sv
module mmc_ctrl
  import mmc_pkg::*;
#(
  parameter int REF_DIV     = 2,
  parameter int SLOW_FACTOR = 4,
  parameter bit HAS_LATCH_B = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] modeSel,
  input  logic       extLatchSel,
  input  logic       slowRef,
  input  logic       swClear,
  input  logic       swLatch,
  input  logic       inA,
  input  logic       inB,
  input  logic       inCl,
  output dpStrobe_t  strobe
);
  chanMode_e  mode;
  logic [2:0] syncIn;
  logic [2:0] prevIn;
  logic       refTick;
  logic       aNow, bNow, clNow, aOld, bOld, clOld;
  logic       aEdge, bEdge, clRise, clFall;

  assign mode = chanMode_e'(modeSel);

  mmc_sync #(.WIDTH(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({inCl, inB, inA}),
    .syncOut (syncIn)
  );

  mmc_refdiv #(.BASE_DIV(REF_DIV), .SLOW_FACTOR(SLOW_FACTOR)) u_refdiv (
    .clk  (clk),
    .rstN (rstN),
    .slow (slowRef),
    .tick (refTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  assign {clNow, bNow, aNow} = syncIn;
  assign {clOld, bOld, aOld} = prevIn;
  assign aEdge  = aNow ^ aOld;
  assign bEdge  = bNow ^ bOld;
  assign clRise = clNow & ~clOld;
  assign clFall = ~clNow & clOld;

  always_comb begin
    strobe        = '0;
    strobe.clr    = swClear;
    strobe.errClr = swClear;
    strobe.capA   = swLatch;
    case (mode)
      MODE_STEPDIR: begin
        if (aNow && !aOld) begin
          strobe.inc = enable & bNow;
          strobe.dec = enable & ~bNow;
        end
        if (clRise) begin
          if (extLatchSel) strobe.capA = 1'b1;
          else             strobe.clr  = 1'b1;
        end
      end
      MODE_QUAD: begin
        if (aEdge && bEdge) begin
          strobe.errSet = 1'b1;
        end else if (aEdge || bEdge) begin
          // A leading B counts up
          strobe.inc = enable & (aNow ^ bOld);
          strobe.dec = enable & ~(aNow ^ bOld);
        end
        if (clRise) begin
          if (extLatchSel) strobe.capA = 1'b1;
          else             strobe.clr  = 1'b1;
        end
      end
      MODE_PULSE: begin
        strobe.inc = enable & refTick;
        if (clRise) strobe.capA = 1'b1;
        strobe.capB = HAS_LATCH_B & clFall;
      end
      default: ;
    endcase
  end

  assert_one_direction_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.inc && strobe.dec));

  assert_pulse_no_ext_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PULSE && !swClear) |-> !strobe.clr && !strobe.dec);

  assert_disabled_no_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strobe.inc && !strobe.dec);
endmodule

// File: rtl/mmc_dp.sv
module mmc_dp
  import mmc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter bit HAS_LATCH_B = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latchA,
  output logic [CNT_W-1:0] latchB,
  output logic             quadErr
);
  always_ff @(posedge clk) begin
    if (!rstN)           count <= '0;
    else if (strobe.clr) count <= '0;
    else if (strobe.inc) count <= count + 1'b1;
    else if (strobe.dec) count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            latchA <= '0;
    else if (strobe.capA) latchA <= count;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              quadErr <= 1'b0;
    else if (strobe.errClr) quadErr <= 1'b0;
    else if (strobe.errSet) quadErr <= 1'b1;
  end

  generate
    if (HAS_LATCH_B) begin : g_latchB
      always_ff @(posedge clk) begin
        if (!rstN)            latchB <= '0;
        else if (strobe.capB) latchB <= count;
      end
    end else begin : g_noLatchB
      assign latchB = '0;
    end
  endgenerate

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> count == '0);

  assert_step_up_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.clr) |=> count == $past(count) + CNT_W'(1));

  assert_step_down_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.clr && !strobe.inc) |=> count == $past(count) - CNT_W'(1));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.dec && !strobe.clr) |=> $stable(count));

  assert_capture_old_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capA |=> latchA == $past(count));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (quadErr && !strobe.errClr) |=> quadErr);
endmodule

// File: rtl/mmc_channel.sv
module mmc_channel
  import mmc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int REF_DIV     = 2,
  parameter int SLOW_FACTOR = 4,
  parameter bit HAS_LATCH_B = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       modeSel,
  input  logic             extLatchSel,
  input  logic             slowRef,
  input  logic             swClear,
  input  logic             swLatch,
  input  logic             inA,
  input  logic             inB,
  input  logic             inCl,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latchA,
  output logic [CNT_W-1:0] latchB,
  output logic             quadErr
);
  dpStrobe_t strobe;

  mmc_ctrl #(
    .REF_DIV     (REF_DIV),
    .SLOW_FACTOR (SLOW_FACTOR),
    .HAS_LATCH_B (HAS_LATCH_B)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .modeSel     (modeSel),
    .extLatchSel (extLatchSel),
    .slowRef     (slowRef),
    .swClear     (swClear),
    .swLatch     (swLatch),
    .inA         (inA),
    .inB         (inB),
    .inCl        (inCl),
    .strobe      (strobe)
  );

  mmc_dp #(
    .CNT_W       (CNT_W),
    .HAS_LATCH_B (HAS_LATCH_B)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .count   (count),
    .latchA  (latchA),
    .latchB  (latchB),
    .quadErr (quadErr)
  );
endmodule

// File: tb/mmc_channel_tb.sv
module mmc_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 19;

  logic        clk = 1'b0;
  logic        rstN, enable, extLatchSel, slowRef, swClear, swLatch;
  logic        inA, inB, inCl;
  logic [1:0]  modeSel;
  logic [31:0] count, latchA, latchB;
  logic        quadErr;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // Vector layout: {mode[1:0], a, b, expected count[31:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b1, 32'd0},
    {2'd0, 1'b1, 1'b1, 32'd1},
    {2'd0, 1'b0, 1'b1, 32'd1},
    {2'd0, 1'b1, 1'b1, 32'd2},
    {2'd0, 1'b0, 1'b0, 32'd2},
    {2'd0, 1'b1, 1'b0, 32'd1},
    {2'd0, 1'b0, 1'b0, 32'd1},
    {2'd0, 1'b1, 1'b0, 32'd0},
    {2'd0, 1'b0, 1'b0, 32'd0},
    {2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF},
    {2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {2'd1, 1'b1, 1'b0, 32'd0},
    {2'd1, 1'b1, 1'b1, 32'd1},
    {2'd1, 1'b0, 1'b1, 32'd2},
    {2'd1, 1'b0, 1'b0, 32'd3},
    {2'd1, 1'b0, 1'b1, 32'd2},
    {2'd1, 1'b1, 1'b1, 32'd1},
    {2'd1, 1'b1, 1'b0, 32'd0},
    {2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF}
  };

  mmc_channel #(.REF_DIV(2), .SLOW_FACTOR(4)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .extLatchSel(extLatchSel), .slowRef(slowRef), .swClear(swClear),
    .swLatch(swLatch), .inA(inA), .inB(inB), .inCl(inCl),
    .count(count), .latchA(latchA), .latchB(latchB), .quadErr(quadErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clkPulse();
    @(negedge clk) inA = 1'b1;
    settle();
    @(negedge clk) inA = 1'b0;
    settle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, aHold;
    rstN = 1'b0; enable = 1'b1; modeSel = 2'd0; extLatchSel = 1'b0;
    slowRef = 1'b0; swClear = 1'b0; swLatch = 1'b0;
    inA = 1'b0; inB = 1'b0; inCl = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 32'd0);
    chk("R1 latchA", latchA, 32'd0);
    chk("R1 latchB", latchB, 32'd0);
    chk("R1 quadErr", {31'd0, quadErr}, 32'd0);
    rstN = 1'b1;
    settle();

    // Table: step/direction (R2, wrap R10) then quadrature (R3, wrap R10)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      modeSel = VEC[i][35:34];
      inA     = VEC[i][33];
      inB     = VEC[i][32];
      settle();
      chk((VEC[i][35:34] == 2'd0) ? "R2/R10 table" : "R3/R10 table", count, VEC[i][31:0]);
    end

    // R4: both phases change together
    @(negedge clk) begin inA = 1'b1; inB = 1'b1; end
    settle();
    chk("R4 count held", count, 32'hFFFF_FFFF);
    chk("R4 error set", {31'd0, quadErr}, 32'd1);
    @(negedge clk) begin modeSel = 2'd0; inA = 1'b0; inB = 1'b0; end
    settle();
    chk("R4 error sticky", {31'd0, quadErr}, 32'd1);
    @(negedge clk) swClear = 1'b1;
    @(negedge clk) swClear = 1'b0;
    chk("R8 clear count", count, 32'd0);
    chk("R4 error cleared", {31'd0, quadErr}, 32'd0);

    // R9: disabled, no steps
    @(negedge clk) begin enable = 1'b0; inB = 1'b1; end
    settle();
    clkPulse();
    clkPulse();
    chk("R9 hold while disabled", count, 32'd0);
    enable = 1'b1;

    // R5: external line captures or clears
    clkPulse(); clkPulse(); clkPulse();
    @(negedge clk) begin extLatchSel = 1'b1; inCl = 1'b1; end
    settle();
    chk("R5 capture", latchA, 32'd3);
    chk("R5 count kept", count, 32'd3);
    @(negedge clk) inCl = 1'b0;
    settle();
    chk("R5 fall ignored count", count, 32'd3);
    clkPulse();
    @(negedge clk) begin extLatchSel = 1'b0; inCl = 1'b1; end
    settle();
    chk("R5 clear", count, 32'd0);
    chk("R5 latch untouched", latchA, 32'd3);
    @(negedge clk) inCl = 1'b0;
    settle();

    // R8: software capture
    clkPulse(); clkPulse();
    @(negedge clk) swLatch = 1'b1;
    @(negedge clk) swLatch = 1'b0;
    chk("R8 sw capture", latchA, 32'd2);

    // R11: capture and clear in the same cycle
    clkPulse(); clkPulse(); clkPulse();
    @(negedge clk) begin swLatch = 1'b1; swClear = 1'b1; end
    @(negedge clk) begin swLatch = 1'b0; swClear = 1'b0; end
    chk("R11 old value captured", latchA, 32'd5);
    chk("R11 count cleared", count, 32'd0);

    // R6: reference tick rate
    @(negedge clk) modeSel = 2'd2;
    repeat (8) @(negedge clk);
    c0 = count;
    repeat (20) @(negedge clk);
    chk("R6 fast rate", count - c0, 32'd10);
    @(negedge clk) slowRef = 1'b1;
    repeat (16) @(negedge clk);
    c0 = count;
    repeat (40) @(negedge clk);
    chk("R6 slow rate", count - c0, 32'd5);

    // R7: rising edge to latchA, falling to latchB
    @(negedge clk) inCl = 1'b1;
    repeat (40) @(negedge clk);
    aHold = latchA;
    inCl = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 width from latches", latchB - latchA, 32'd5);
    chk("R7 fall leaves latchA", latchA, aHold);
    chk("R7 not cleared", {31'd0, (count >= latchB) && (count - latchB <= 32'd10)}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule